// File: doc/BRIEF.md
# Cache Tag Array Software Window

This block lets privileged software inspect and overwrite the tag store of a four-way set-associative cache. It watches a 32-bit request bus. A request whose upper address byte marks the tag window is decoded into a set number, a way number and an associative flag. A read returns that line's stored tag, valid and dirty flags, together with the replacement-order field that the whole set shares.

A plain write replaces those fields. Before it can do so on a line that is both valid and dirty, the old contents must be saved. The block raises a write-back request toward memory carrying the displaced tag and the line's position. It keeps that request up until memory acknowledges, and only then stores the new fields and answers the CPU. Writes that ask for associative behaviour, and accesses of the wrong width or from instruction fetch, are refused with an error response. The data array and normal lookups are handled elsewhere.

Top module: `ctag_window`

## Requirements
- R1: Only requests with addr[31:24] = 0xF0 are served; any other address produces no response and leaves every stored field unchanged.
- R2: addr[11:4] selects one of 256 sets and addr[13:12] selects way 0 to 3 (binary); every set and way holds its own tag, valid and dirty state.
- R3: The read word is packed as tag at bits 31:10, shared replacement field at bits 9:4, dirty at bit 1 and valid at bit 0. Bits 31:29 and 3:2 always read as zero, whatever was written there, and the same holds for the top three bits of the write-back tag.
- R4: A read of size 2'b10 (32-bit) that is not an instruction fetch is answered with rsp_valid high and rsp_err low in the cycle after it is accepted, whatever the value of addr[3].
- R5: A 32-bit write with addr[3] = 0 to a line that is not both valid and dirty stores the new fields and is answered without error in the next cycle, with no write-back request.
- R6: The 6-bit replacement field belongs to the set: a write to any way of a set replaces it, and a read of any way of that set returns it.
- R7: A write to a line whose dirty and valid flags are both 1 raises wb_req in the next cycle, carrying the old tag, set and way. wb_req holds steady until wb_ack is sampled high, and no response is given before then. The cycle after the acknowledge, rsp_valid is high and the new fields are stored. A line that is dirty but not valid needs no write-back.
- R8: A write with addr[3] = 1 is answered with rsp_err in the next cycle and changes nothing.
- R9: A request with size other than 2'b10, or with ifetch high, is answered with rsp_err in the next cycle and changes nothing.
- R10: After reset, every valid flag, dirty flag and replacement field reads as zero, ready is high and no write-back is pending.
- R11: While a write-back is outstanding, ready is low and any new request is dropped without effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request strobe, one cycle per access |
| addr | input | 32 | Access address |
| we | input | 1 | 1 = write, 0 = read |
| size | input | 2 | Access width, 2'b10 = 32-bit |
| ifetch | input | 1 | Request comes from instruction fetch |
| wdata | input | 32 | Write data word |
| ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Response is an error |
| rdata | output | 32 | Read data word |
| wb_req | output | 1 | Write-back request to memory |
| wb_tag | output | 22 | Tag of the line being written back |
| wb_set | output | 8 | Set of the line being written back |
| wb_way | output | 2 | Way of the line being written back |
| wb_ack | input | 1 | Memory has taken the write-back |

## Verification
Every set and way is read after reset and then written with distinct tag, flag and replacement values. Reading all 1024 lines back, with the associative bit alternating, shows whether any set or way bits are mis-decoded and whether the per-set field is shared. Stray bits written into the zero-reading positions reveal packing faults. Refused accesses (associative write, wrong size, instruction fetch, foreign address byte) are each followed by a read-back, which tells a rejected access apart from a silently performed one. A dirty-valid overwrite with a long acknowledge delay and a competing request shows the write-back handshake, its timing and the busy drop. A dirty-but-invalid line shows that only both flags together cause a write-back.

// File: rtl/ctag_pkg.sv
// Shared constants and types for the cache tag window.
// Assumes the address and data field positions below are fixed by software.
package ctag_pkg;
    localparam logic [7:0] WIN_ID    = 8'hF0;  // upper address byte of the window
    localparam logic [1:0] SIZE_LONG = 2'b10;  // only accepted access width
    localparam int         SET_LSB   = 4;      // set index starts at address bit 4
    localparam int         ASSOC_BIT = 3;      // associative flag position
    localparam int         LRU_LSB   = 4;      // replacement field starts at data bit 4
    localparam int         TAG_LSB   = 10;     // tag field starts at data bit 10
    localparam int         TAG_FIELD = 32 - TAG_LSB;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WB   = 1'b1
    } ctl_state_t;
endpackage

// File: rtl/ctag_decode.sv
// Address and attribute decode for the tag window.
// Purely combinational; assumes the set field sits just above bit 3 and
// the way field just above the set field.
module ctag_decode
    import ctag_pkg::*;
#(
    parameter int SET_W = 8,
    parameter int WAY_W = 2
) (
    input  logic [31:0]      addr,
    input  logic             we,
    input  logic [1:0]       size,
    input  logic             ifetch,
    output logic             hit,
    output logic [SET_W-1:0] set_idx,
    output logic [WAY_W-1:0] way_idx,
    output logic             fault
);
    localparam int WAY_LSB = SET_LSB + SET_W;

    logic assoc;

    // Split the address into window match, position and associative flag.
    always_comb begin
        hit     = (addr[31:24] == WIN_ID);
        set_idx = addr[SET_LSB +: SET_W];
        way_idx = addr[WAY_LSB +: WAY_W];
        assoc   = addr[ASSOC_BIT];
    end

    // Refuse wrong widths, fetches and associative writes.
    always_comb begin
        fault = (size != SIZE_LONG) || ifetch || (we && assoc);
    end

    logic unused_addr;
    assign unused_addr = ^{addr[23:WAY_LSB+WAY_W], addr[2:0]};
endmodule

// File: rtl/ctag_store.sv
// Tag, flag and replacement storage for every set and way.
// One combinational read port and one write port; valid, dirty and the
// shared per-set replacement field are cleared by synchronous reset,
// tags are not reset.
module ctag_store #(
    parameter int SET_W = 8,
    parameter int WAY_W = 2,
    parameter int TAG_W = 19,
    parameter int LRU_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set,
    input  logic [WAY_W-1:0] rd_way,
    output logic [TAG_W-1:0] rd_tag,
    output logic [LRU_W-1:0] rd_lru,
    output logic             rd_u,
    output logic             rd_v,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [LRU_W-1:0] wr_lru,
    input  logic             wr_u,
    input  logic             wr_v
);
    localparam int SETS = 1 << SET_W;
    localparam int WAYS = 1 << WAY_W;

    logic [TAG_W-1:0] way_tag [WAYS];
    logic [WAYS-1:0]  way_u;
    logic [WAYS-1:0]  way_v;
    logic [LRU_W-1:0] lru_mem [SETS];

    for (genvar gw = 0; gw < WAYS; gw++) begin : g_way
        logic [TAG_W-1:0] tag_mem [SETS];
        logic [SETS-1:0]  v_bits;
        logic [SETS-1:0]  u_bits;
        logic             sel;

        assign sel = wr_en && (wr_way == WAY_W'(gw));

        // Store the tag of this way on a commit.
        always_ff @(posedge clk) begin
            if (sel) begin
                tag_mem[wr_set] <= wr_tag;
            end
        end

        // Keep valid and dirty flags of this way, cleared on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_bits <= '0;
                u_bits <= '0;
            end else if (sel) begin
                v_bits[wr_set] <= wr_v;
                u_bits[wr_set] <= wr_u;
            end
        end

        assign way_tag[gw] = tag_mem[rd_set];
        assign way_v[gw]   = v_bits[rd_set];
        assign way_u[gw]   = u_bits[rd_set];
    end

    // Keep the replacement field shared by all ways of a set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) begin
                lru_mem[i] <= '0;
            end
        end else if (wr_en) begin
            lru_mem[wr_set] <= wr_lru;
        end
    end

    // Select the addressed way for the read port.
    always_comb begin
        rd_tag = way_tag[rd_way];
        rd_v   = way_v[rd_way];
        rd_u   = way_u[rd_way];
        rd_lru = lru_mem[rd_set];
    end
endmodule

// File: rtl/ctag_ctrl.sv
// Sequencer for the tag window: answers reads, commits writes, and runs the
// write-back handshake before overwriting a dirty valid line.
// Assumes req is a one-cycle strobe and is ignored while not ready.
module ctag_ctrl
    import ctag_pkg::*;
#(
    parameter int SET_W = 8,
    parameter int WAY_W = 2,
    parameter int TAG_W = 19,
    parameter int LRU_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic                 we,
    input  logic [31:0]          wdata,
    input  logic                 hit,
    input  logic                 fault,
    input  logic [SET_W-1:0]     dec_set,
    input  logic [WAY_W-1:0]     dec_way,
    input  logic [TAG_W-1:0]     old_tag,
    input  logic [LRU_W-1:0]     old_lru,
    input  logic                 old_u,
    input  logic                 old_v,
    input  logic                 wb_ack,
    output logic                 ready,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [31:0]          rdata,
    output logic                 wb_req,
    output logic [TAG_FIELD-1:0] wb_tag,
    output logic [SET_W-1:0]     wb_set,
    output logic [WAY_W-1:0]     wb_way,
    output logic                 commit_en,
    output logic [SET_W-1:0]     commit_set,
    output logic [WAY_W-1:0]     commit_way,
    output logic [TAG_W-1:0]     commit_tag,
    output logic [LRU_W-1:0]     commit_lru,
    output logic                 commit_u,
    output logic                 commit_v
);
    ctl_state_t       state;
    logic             accept;
    logic             evict;
    logic [TAG_W-1:0] new_tag;
    logic [LRU_W-1:0] new_lru;
    logic             new_u;
    logic             new_v;
    logic [TAG_W-1:0] pend_tag;
    logic [LRU_W-1:0] pend_lru;
    logic             pend_u;
    logic             pend_v;
    logic [31:0]      rd_word;

    // Extract the new fields from the write word and classify the request.
    always_comb begin
        new_tag = wdata[TAG_LSB +: TAG_W];
        new_lru = wdata[LRU_LSB +: LRU_W];
        new_u   = wdata[1];
        new_v   = wdata[0];
        ready   = (state == ST_IDLE);
        accept  = req && hit && ready;
        evict   = old_u && old_v;
    end

    // Pack the addressed line into the read word; unused bits stay zero.
    always_comb begin
        rd_word                    = '0;
        rd_word[TAG_LSB +: TAG_W]  = old_tag;
        rd_word[LRU_LSB +: LRU_W]  = old_lru;
        rd_word[1]                 = old_u;
        rd_word[0]                 = old_v;
    end

    // Choose what the storage writes this cycle: direct or after write-back.
    always_comb begin
        if (state == ST_IDLE) begin
            commit_en  = accept && !fault && we && !evict;
            commit_set = dec_set;
            commit_way = dec_way;
            commit_tag = new_tag;
            commit_lru = new_lru;
            commit_u   = new_u;
            commit_v   = new_v;
        end else begin
            commit_en  = wb_ack;
            commit_set = wb_set;
            commit_way = wb_way;
            commit_tag = pend_tag;
            commit_lru = pend_lru;
            commit_u   = pend_u;
            commit_v   = pend_v;
        end
    end

    // Advance the sequencer and register responses and write-back fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rdata     <= '0;
            wb_req    <= 1'b0;
            wb_tag    <= '0;
            wb_set    <= '0;
            wb_way    <= '0;
            pend_tag  <= '0;
            pend_lru  <= '0;
            pend_u    <= 1'b0;
            pend_v    <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (fault) begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= 1'b1;
                            rdata     <= '0;
                        end else if (!we) begin
                            rsp_valid <= 1'b1;
                            rdata     <= rd_word;
                        end else if (evict) begin
                            state    <= ST_WB;
                            wb_req   <= 1'b1;
                            wb_tag   <= TAG_FIELD'(old_tag);
                            wb_set   <= dec_set;
                            wb_way   <= dec_way;
                            pend_tag <= new_tag;
                            pend_lru <= new_lru;
                            pend_u   <= new_u;
                            pend_v   <= new_v;
                        end else begin
                            rsp_valid <= 1'b1;
                            rdata     <= '0;
                        end
                    end
                end
                ST_WB: begin
                    if (wb_ack) begin
                        state     <= ST_IDLE;
                        wb_req    <= 1'b0;
                        rsp_valid <= 1'b1;
                        rdata     <= '0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^{wdata[31:TAG_LSB+TAG_W], wdata[LRU_LSB-1:2]};
endmodule

// File: rtl/ctag_window.sv
// Top of the cache tag window: decode, storage and sequencer.
// Assumes a single requester; the data array lives elsewhere.
module ctag_window
    import ctag_pkg::*;
#(
    parameter int SET_W = 8,
    parameter int WAY_W = 2,
    parameter int TAG_W = 19,
    parameter int LRU_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic [31:0]          addr,
    input  logic                 we,
    input  logic [1:0]           size,
    input  logic                 ifetch,
    input  logic [31:0]          wdata,
    output logic                 ready,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [31:0]          rdata,
    output logic                 wb_req,
    output logic [TAG_FIELD-1:0] wb_tag,
    output logic [SET_W-1:0]     wb_set,
    output logic [WAY_W-1:0]     wb_way,
    input  logic                 wb_ack
);
    logic             hit;
    logic             fault;
    logic [SET_W-1:0] dec_set;
    logic [WAY_W-1:0] dec_way;
    logic [TAG_W-1:0] old_tag;
    logic [LRU_W-1:0] old_lru;
    logic             old_u;
    logic             old_v;
    logic             commit_en;
    logic [SET_W-1:0] commit_set;
    logic [WAY_W-1:0] commit_way;
    logic [TAG_W-1:0] commit_tag;
    logic [LRU_W-1:0] commit_lru;
    logic             commit_u;
    logic             commit_v;

    ctag_decode #(.SET_W(SET_W), .WAY_W(WAY_W)) u_decode (
        .addr    (addr),
        .we      (we),
        .size    (size),
        .ifetch  (ifetch),
        .hit     (hit),
        .set_idx (dec_set),
        .way_idx (dec_way),
        .fault   (fault)
    );

    ctag_store #(.SET_W(SET_W), .WAY_W(WAY_W), .TAG_W(TAG_W), .LRU_W(LRU_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_set (dec_set),
        .rd_way (dec_way),
        .rd_tag (old_tag),
        .rd_lru (old_lru),
        .rd_u   (old_u),
        .rd_v   (old_v),
        .wr_en  (commit_en),
        .wr_set (commit_set),
        .wr_way (commit_way),
        .wr_tag (commit_tag),
        .wr_lru (commit_lru),
        .wr_u   (commit_u),
        .wr_v   (commit_v)
    );

    ctag_ctrl #(.SET_W(SET_W), .WAY_W(WAY_W), .TAG_W(TAG_W), .LRU_W(LRU_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .we         (we),
        .wdata      (wdata),
        .hit        (hit),
        .fault      (fault),
        .dec_set    (dec_set),
        .dec_way    (dec_way),
        .old_tag    (old_tag),
        .old_lru    (old_lru),
        .old_u      (old_u),
        .old_v      (old_v),
        .wb_ack     (wb_ack),
        .ready      (ready),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .rdata      (rdata),
        .wb_req     (wb_req),
        .wb_tag     (wb_tag),
        .wb_set     (wb_set),
        .wb_way     (wb_way),
        .commit_en  (commit_en),
        .commit_set (commit_set),
        .commit_way (commit_way),
        .commit_tag (commit_tag),
        .commit_lru (commit_lru),
        .commit_u   (commit_u),
        .commit_v   (commit_v)
    );
endmodule

// File: rtl/ctag_window_chk.sv
// Protocol checker for the cache tag window, bound to the top module.
// Observes ports only.
module ctag_window_chk
    import ctag_pkg::*;
#(
    parameter int SET_W = 8,
    parameter int WAY_W = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req,
    input logic [31:0]          addr,
    input logic                 we,
    input logic [1:0]           size,
    input logic                 ifetch,
    input logic                 ready,
    input logic                 rsp_valid,
    input logic                 rsp_err,
    input logic [31:0]          rdata,
    input logic                 wb_req,
    input logic [TAG_FIELD-1:0] wb_tag,
    input logic [SET_W-1:0]     wb_set,
    input logic [WAY_W-1:0]     wb_way,
    input logic                 wb_ack
);
    logic take;
    logic in_win;
    assign take   = req && ready;
    assign in_win = (addr[31:24] == WIN_ID);

    p_miss_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        take && !in_win |=> !rsp_valid);

    p_zero_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rdata[31:29] == 3'b000) && (rdata[3:2] == 2'b00));

    p_wb_tag_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> (wb_tag[TAG_FIELD-1 -: 3] == 3'b000));

    p_read_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take && in_win && !we && (size == SIZE_LONG) && !ifetch |=> rsp_valid && !rsp_err);

    p_wb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && !wb_ack |=> wb_req && $stable(wb_tag) && $stable(wb_set) && $stable(wb_way) && !rsp_valid);

    p_wb_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && wb_ack |=> !wb_req && rsp_valid && !rsp_err);

    p_assoc_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take && in_win && we && addr[ASSOC_BIT] |=> rsp_valid && rsp_err);

    p_size_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take && in_win && ((size != SIZE_LONG) || ifetch) |=> rsp_valid && rsp_err);

    p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> !ready);
endmodule

bind ctag_window ctag_window_chk #(.SET_W(SET_W), .WAY_W(WAY_W)) u_chk (.*);

// File: tb/ctag_window_bench.sv
// Self-checking bench: sweeps every set and way, then the refusal and
// write-back cases. Inputs change on the falling edge; outputs are sampled there.
module ctag_window_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [31:0] addr = '0;
    logic        we = 1'b0;
    logic [1:0]  size = 2'b10;
    logic        ifetch = 1'b0;
    logic [31:0] wdata = '0;
    logic        ready, rsp_valid, rsp_err, wb_req;
    logic [31:0] rdata;
    logic [21:0] wb_tag;
    logic [7:0]  wb_set;
    logic [1:0]  wb_way;
    logic        wb_ack = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    logic [18:0] m_tag [4][256];
    logic [5:0]  m_lru [256];
    logic        m_u   [4][256];
    logic        m_v   [4][256];

    always #5 clk = ~clk;

    ctag_window u_ctag_window (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .we(we), .size(size),
        .ifetch(ifetch), .wdata(wdata), .ready(ready), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rdata(rdata), .wb_req(wb_req), .wb_tag(wb_tag),
        .wb_set(wb_set), .wb_way(wb_way), .wb_ack(wb_ack)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_addr(input int s, input int w, input bit assoc, input logic [7:0] top);
        return {top, 10'b0, 2'(w), 8'(s), assoc, 3'b000};
    endfunction

    function automatic logic [21:0] mk_raw(input int s, input int w, input int salt);
        return {3'(s + w + salt), 19'(s * 613 + w * 7919 + salt * 101 + 3)};
    endfunction

    function automatic logic [31:0] mk_word(input logic [21:0] raw, input logic [5:0] lru, input bit u, input bit v);
        return {raw, lru, 2'b11, u, v};
    endfunction

    function automatic logic [31:0] exp_word(input int s, input int w);
        return {3'b000, m_tag[w][s], m_lru[s], 2'b00, m_u[w][s], m_v[w][s]};
    endfunction

    // One request cycle; results sampled one falling edge later.
    task automatic access(input logic [31:0] a, input bit w, input logic [31:0] d,
                          input logic [1:0] sz, input bit fe,
                          output bit gv, output bit ge, output logic [31:0] gd, output bit gwb);
        req = 1'b1; addr = a; we = w; wdata = d; size = sz; ifetch = fe;
        @(negedge clk);
        req = 1'b0; we = 1'b0; size = 2'b10; ifetch = 1'b0;
        gv = rsp_valid; ge = rsp_err; gd = rdata; gwb = wb_req;
    endtask

    task automatic rd_check(input int s, input int w, input bit assoc, input string tag);
        bit gv, ge, gwb;
        logic [31:0] gd;
        access(mk_addr(s, w, assoc, 8'hF0), 1'b0, '0, 2'b10, 1'b0, gv, ge, gd, gwb);
        check(gv && !ge && gd == exp_word(s, w), tag, gd, exp_word(s, w));
    endtask

    task automatic wr_plain(input int s, input int w, input logic [21:0] raw, input logic [5:0] lru,
                            input bit u, input bit v, input string tag);
        bit gv, ge, gwb;
        logic [31:0] gd;
        access(mk_addr(s, w, 1'b0, 8'hF0), 1'b1, mk_word(raw, lru, u, v), 2'b10, 1'b0, gv, ge, gd, gwb);
        check(gv && !ge && !gwb, tag, {29'b0, gv, ge, gwb}, 32'h4);
        m_tag[w][s] = raw[18:0]; m_lru[s] = lru; m_u[w][s] = u; m_v[w][s] = v;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        bit gv, ge, gwb;
        logic [31:0] gd;
        logic [21:0] raw;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: idle state after reset
        check(ready && !rsp_valid && !wb_req, "R10 idle after reset", {29'b0, ready, rsp_valid, wb_req}, 32'h4);

        // R10: every flag and shared field clear after reset
        for (int s = 0; s < 256; s++) begin
            for (int w = 0; w < 4; w++) begin
                access(mk_addr(s, w, 1'b0, 8'hF0), 1'b0, '0, 2'b10, 1'b0, gv, ge, gd, gwb);
                check(gv && !ge && gd[9:0] == 10'b0, "R10 cleared flags", gd & 32'h3FF, 32'h0);
            end
        end

        // R5 R2 R6: fill every line, no dirty flags yet
        for (int s = 0; s < 256; s++) begin
            for (int w = 0; w < 4; w++) begin
                wr_plain(s, w, mk_raw(s, w, 0), 6'(s * 3 + w), 1'b0, bit'((s ^ w) % 3 != 0), "R5 plain write");
            end
        end

        // R2 R3 R4 R6: read all back, associative bit alternating
        for (int s = 0; s < 256; s++) begin
            for (int w = 0; w < 4; w++) begin
                rd_check(s, w, bit'(w & 1), "R2 R3 R4 R6 readback");
            end
        end

        // R8: associative write refused and ignored
        access(mk_addr(7, 1, 1'b1, 8'hF0), 1'b1, mk_word(22'h155555, 6'h2A, 1'b1, 1'b1), 2'b10, 1'b0, gv, ge, gd, gwb);
        check(gv && ge, "R8 assoc write error", {30'b0, gv, ge}, 32'h3);
        rd_check(7, 1, 1'b0, "R8 assoc write no change");

        // R9: wrong sizes and instruction fetch refused and ignored
        access(mk_addr(8, 2, 1'b0, 8'hF0), 1'b1, mk_word(22'h0ABCDE, 6'h11, 1'b0, 1'b1), 2'b01, 1'b0, gv, ge, gd, gwb);
        check(gv && ge, "R9 halfword write error", {30'b0, gv, ge}, 32'h3);
        access(mk_addr(8, 2, 1'b0, 8'hF0), 1'b1, mk_word(22'h0ABCDE, 6'h11, 1'b0, 1'b1), 2'b10, 1'b1, gv, ge, gd, gwb);
        check(gv && ge, "R9 fetch write error", {30'b0, gv, ge}, 32'h3);
        rd_check(8, 2, 1'b0, "R9 refused writes no change");
        access(mk_addr(8, 2, 1'b0, 8'hF0), 1'b0, '0, 2'b00, 1'b0, gv, ge, gd, gwb);
        check(gv && ge, "R9 byte read error", {30'b0, gv, ge}, 32'h3);
        access(mk_addr(8, 2, 1'b0, 8'hF0), 1'b0, '0, 2'b10, 1'b1, gv, ge, gd, gwb);
        check(gv && ge, "R9 fetch read error", {30'b0, gv, ge}, 32'h3);

        // R1: foreign upper byte ignored
        access(mk_addr(9, 0, 1'b0, 8'hF1), 1'b1, mk_word(22'h3FFFFF, 6'h3F, 1'b0, 1'b1), 2'b10, 1'b0, gv, ge, gd, gwb);
        check(!gv, "R1 foreign write silent", {31'b0, gv}, 32'h0);
        access(mk_addr(9, 0, 1'b0, 8'h70), 1'b0, '0, 2'b10, 1'b0, gv, ge, gd, gwb);
        check(!gv, "R1 foreign read silent", {31'b0, gv}, 32'h0);
        rd_check(9, 0, 1'b0, "R1 foreign write no change");

        // R7: make a line dirty and valid, then overwrite it
        wr_plain(20, 2, mk_raw(20, 2, 5), 6'h15, 1'b1, 1'b1, "R7 set dirty valid");
        raw = mk_raw(20, 2, 9);
        req = 1'b1; addr = mk_addr(20, 2, 1'b0, 8'hF0); we = 1'b1; wdata = mk_word(raw, 6'h2C, 1'b0, 1'b1);
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        check(wb_req && !rsp_valid && !ready, "R7 write-back raised", {29'b0, wb_req, rsp_valid, ready}, 32'h4);
        check(wb_tag == {3'b000, m_tag[2][20]}, "R7 R3 write-back tag", 32'(wb_tag), 32'({3'b000, m_tag[2][20]}));
        check(wb_set == 8'd20 && wb_way == 2'd2, "R7 write-back position", {22'b0, wb_set, wb_way}, {22'b0, 8'd20, 2'd2});
        // R11: competing request during write-back is dropped
        req = 1'b1; addr = mk_addr(21, 0, 1'b0, 8'hF0); we = 1'b1; wdata = mk_word(22'h000777, 6'h01, 1'b1, 1'b1);
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        for (int k = 0; k < 3; k++) begin
            check(wb_req && !rsp_valid && !ready, "R7 R11 held while waiting", {29'b0, wb_req, rsp_valid, ready}, 32'h4);
            @(negedge clk);
        end
        wb_ack = 1'b1;
        @(negedge clk);
        wb_ack = 1'b0;
        check(rsp_valid && !rsp_err && !wb_req, "R7 response after ack", {29'b0, rsp_valid, rsp_err, wb_req}, 32'h4);
        m_tag[2][20] = raw[18:0]; m_lru[20] = 6'h2C; m_u[2][20] = 1'b0; m_v[2][20] = 1'b1;
        @(negedge clk);
        rd_check(20, 2, 1'b0, "R7 new fields stored");
        rd_check(20, 0, 1'b1, "R6 shared field after write-back");
        rd_check(21, 0, 1'b0, "R11 dropped request no change");

        // R7: dirty but invalid line needs no write-back
        wr_plain(30, 1, mk_raw(30, 1, 3), 6'h05, 1'b1, 1'b0, "R7 set dirty invalid");
        wr_plain(30, 1, mk_raw(30, 1, 4), 6'h06, 1'b1, 1'b1, "R7 dirty invalid no write-back");
        rd_check(30, 1, 1'b0, "R7 dirty invalid stored");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule